// File: doc/BRIEF.md
# I2C Target Controller with Per-Event Status Codes

This block is a 7-bit-addressed I2C target (slave) that a host processor runs one byte at a time through a small register set. It does not buffer bytes. After each bus event it records a fixed 8-bit code describing what happened and sets an event flag. While the target is taking part in a transfer, it also holds SCL low until the host writes a 1 to the flag. The host reads the code, moves a byte into or out of the data register, and then lets the transfer go on.

The bus pins are seen through a two-stage synchronizer. START is recognised as SDA falling while SCL is high, and STOP as SDA rising while SCL is high. The block drives SDA and SCL only as open-drain pull-down enables. The host sees three write-only registers, chosen by `wr_sel_i`:

- **Select 0, own address.** Bits 7:1 hold the own address. Bit 0 enables replies to the general-call address 0.
- **Select 1, data.** The byte to send next. A received byte also lands here.
- **Select 2, control.** Bit 0 is flag-clear: writing 1 clears the flag, writing 0 has no effect. Bit 1 is ACK enable, bit 2 is interface enable and bit 3 is interrupt enable.

Top module: `i2c_tgt_status`

## Requirements
- R1: After reset the flag is 0, `status_o` reads 0xF8, the interrupt output is low and neither bus pin is driven.
- R2: A first byte whose upper seven bits equal the own address is acknowledged when ACK enable is set. Bit 0 of that byte selects the code: 0 (write) posts 0x60 and 1 (read) posts 0xA8.
- R3: Any other address is not acknowledged and leaves the flag and status unchanged.
- R4: Address 0 with a write bit is treated as a general call. It is acknowledged with code 0x70 only when address-register bit 0 is set. Its data bytes post 0x90 when acknowledged and 0x98 when not.
- R5: Each received data byte is stored in the data register. With ACK enable set the target acknowledges it and posts 0x80. With ACK enable clear it does not acknowledge, posts 0x88 and ignores the rest of the transfer.
- R6: A STOP or repeated START seen while the target is addressed posts 0xA0. The same conditions seen while it is not addressed post nothing.
- R7: In a read, the data register is shifted out MSB first. After the controller acknowledges a byte, the target posts 0xB8 if ACK enable is set and 0xC8 if it is clear (the last byte). After a NACK it posts 0xC0. After 0xC8 or 0xC0 it stops taking part until the next START.
- R8: Every posted event sets the flag. The flag clears only when the host writes control bit 0 as 1; writing 0 there leaves it set.
- R9: While the flag is set and the target is addressed, SCL is held low. SCL is released on the same clock edge that clears the flag.
- R10: With interface enable clear, the target acknowledges nothing and posts no events.
- R11: The interrupt output equals the flag ANDed with interrupt enable.
- R12: `status_o` shows the latest code while the flag is set and 0xF8 while it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low |
| wr_en_i | input | 1 | Host register write strobe |
| wr_sel_i | input | 2 | Register select: 0 address, 1 data, 2 control |
| wr_data_i | input | 8 | Host write data |
| data_o | output | 8 | Data register contents |
| status_o | output | 8 | Event code, or 0xF8 when idle |
| flag_o | output | 1 | Event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps all 128 addresses with the general call enabled. Each address must be acknowledged or ignored exactly as R2, R3 and R4 predict. A decoder that also matched on the read/write bit, or that took address 0 as its own, would ACK the wrong bytes.

The bench clears ACK enable in the middle of transfers, in both directions. A design that mixed up the 0x88/0x98 or 0xB8/0xC8 choices, or that went on acknowledging after a NACK, would post wrong codes. The same is true of one that posted 0xA0 for a STOP it was not part of.

The bench also checks SCL right after each event and again right after the flag-clear write. A target that released SCL one cycle late, or held it while not addressed, is caught there. So is one whose flag cleared on a 0 write.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = 4;

  // Host register selects
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  // Control bit positions
  localparam int CB_FLAG  = 0;
  localparam int CB_ACK   = 1;
  localparam int CB_IFEN  = 2;
  localparam int CB_IRQEN = 3;

  // Event codes
  localparam logic [7:0] EV_W_ADDR   = 8'h60;
  localparam logic [7:0] EV_GC_ADDR  = 8'h70;
  localparam logic [7:0] EV_RX_ACK   = 8'h80;
  localparam logic [7:0] EV_RX_NACK  = 8'h88;
  localparam logic [7:0] EV_GC_ACK   = 8'h90;
  localparam logic [7:0] EV_GC_NACK  = 8'h98;
  localparam logic [7:0] EV_END      = 8'hA0;
  localparam logic [7:0] EV_R_ADDR   = 8'hA8;
  localparam logic [7:0] EV_TX_ACK   = 8'hB8;
  localparam logic [7:0] EV_TX_NACK  = 8'hC0;
  localparam logic [7:0] EV_TX_LAST  = 8'hC8;
  localparam logic [7:0] EV_NONE     = 8'hF8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK, ST_THOLD
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_prev, sda_prev;
  logic scl_s, sda_s;

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign sda_s_o    = sda_s;
  assign scl_rise_o = !scl_prev && scl_s;
  assign scl_fall_o = scl_prev && !scl_s;
  assign start_o    = scl_prev && scl_s && sda_prev && !sda_s;
  assign stop_o     = scl_prev && scl_s && !sda_prev && sda_s;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_en_i,
  input  logic              ack_en_i,
  input  logic              gc_en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              flag_i,
  input  logic [BYTE_W-1:0] data_reg_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  output logic              sda_oe_o,
  output logic              scl_oe_o,
  output logic              evt_valid_o,
  output logic [7:0]        evt_code_o,
  output logic              rx_load_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic sda_oe_q, sda_oe_d, rw_q, rw_d, gc_q, gc_d, mack_q, mack_d, acked_q, acked_d;
  logic addressed, hit_own, hit_gc;

  assign addressed = (state_q != ST_IDLE) && (state_q != ST_ADDR);
  assign hit_own   = (sh_q[BYTE_W-1:1] == own_addr_i) && (sh_q[BYTE_W-1:1] != '0);
  assign hit_gc    = (sh_q[BYTE_W-1:1] == '0) && gc_en_i && !sh_q[0];

  always_comb begin
    state_d = state_q; cnt_d = cnt_q; sh_d = sh_q; sda_oe_d = sda_oe_q;
    rw_d = rw_q; gc_d = gc_q; mack_d = mack_q; acked_d = acked_q;
    evt_valid_o = 1'b0; evt_code_o = EV_NONE; rx_load_o = 1'b0; rx_byte_o = sh_q;
    if (!if_en_i) begin
      state_d = ST_IDLE; sda_oe_d = 1'b0;
    end else if (start_det_i || stop_det_i) begin
      if (addressed) begin evt_valid_o = 1'b1; evt_code_o = EV_END; end
      state_d  = start_det_i ? ST_ADDR : ST_IDLE;
      cnt_d    = '0;
      sda_oe_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise_i) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s_i};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == CNT_W'(BYTE_W)) begin
            if (state_q == ST_ADDR) begin
              if (ack_en_i && (hit_own || hit_gc)) begin
                state_d = ST_AACK; sda_oe_d = 1'b1;
                rw_d = sh_q[0]; gc_d = hit_gc;
                evt_valid_o = 1'b1;
                evt_code_o  = hit_gc ? EV_GC_ADDR : (sh_q[0] ? EV_R_ADDR : EV_W_ADDR);
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              rx_load_o = 1'b1; acked_d = ack_en_i; sda_oe_d = ack_en_i;
              evt_valid_o = 1'b1; state_d = ST_RACK;
              if (gc_q) evt_code_o = ack_en_i ? EV_GC_ACK : EV_GC_NACK;
              else      evt_code_o = ack_en_i ? EV_RX_ACK : EV_RX_NACK;
            end
          end
        end
        ST_AACK: if (scl_fall_i) begin
          cnt_d = '0;
          if (rw_q) begin
            state_d = ST_TX; sh_d = data_reg_i; sda_oe_d = !data_reg_i[BYTE_W-1];
          end else begin
            state_d = ST_RX; sda_oe_d = 1'b0;
          end
        end
        ST_RACK: if (scl_fall_i) begin
          sda_oe_d = 1'b0; cnt_d = '0;
          state_d  = acked_q ? ST_RX : ST_IDLE;
        end
        ST_TX: if (scl_fall_i) begin
          if (cnt_q == CNT_W'(BYTE_W - 1)) begin
            sda_oe_d = 1'b0; state_d = ST_TACK;
          end else begin
            sh_d = {sh_q[BYTE_W-2:0], 1'b0}; cnt_d = cnt_q + 1'b1;
            sda_oe_d = !sh_q[BYTE_W-2];
          end
        end
        ST_TACK: begin
          if (scl_rise_i) mack_d = !sda_s_i;
          else if (scl_fall_i) begin
            evt_valid_o = 1'b1;
            if (!mack_q)        begin evt_code_o = EV_TX_NACK; state_d = ST_IDLE;  end
            else if (!ack_en_i) begin evt_code_o = EV_TX_LAST; state_d = ST_IDLE;  end
            else                begin evt_code_o = EV_TX_ACK;  state_d = ST_THOLD; end
          end
        end
        ST_THOLD: if (!flag_i) begin
          state_d = ST_TX; cnt_d = '0; sh_d = data_reg_i;
          sda_oe_d = !data_reg_i[BYTE_W-1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; sda_oe_q <= 1'b0;
      rw_q <= 1'b0; gc_q <= 1'b0; mack_q <= 1'b0; acked_q <= 1'b0;
    end else begin
      state_q <= state_d; cnt_q <= cnt_d; sh_q <= sh_d; sda_oe_q <= sda_oe_d;
      rw_q <= rw_d; gc_q <= gc_d; mack_q <= mack_d; acked_q <= acked_d;
    end
  end

  assign sda_oe_o = sda_oe_q;
  assign scl_oe_o = flag_i && (state_q != ST_IDLE);

  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en_i |=> !sda_oe_o);
  a_r3_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start_det_i && !stop_det_i) |-> !evt_valid_o);
  a_r6_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det_i |=> (!sda_oe_o && !scl_oe_o));
endmodule

// File: rtl/i2c_tgt_hostregs.sv
module i2c_tgt_hostregs
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              evt_valid_i,
  input  logic [7:0]        evt_code_i,
  input  logic              rx_load_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic [ADDR_W-1:0] own_addr_o,
  output logic              gc_en_o,
  output logic              ack_en_o,
  output logic              if_en_o,
  output logic              irq_en_o,
  output logic              flag_o,
  output logic [7:0]        status_o,
  output logic [BYTE_W-1:0] data_o
);
  logic [BYTE_W-1:0] addr_q, addr_d, data_q, data_d;
  logic [7:0] code_q, code_d;
  logic flag_q, flag_d, ack_q, ack_d, ifen_q, ifen_d, irqen_q, irqen_d;
  logic wr_ctrl, clr_req;

  assign wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign clr_req = wr_ctrl && wr_data_i[CB_FLAG];

  always_comb begin
    addr_d = addr_q; data_d = data_q; code_d = code_q; flag_d = flag_q;
    ack_d = ack_q; ifen_d = ifen_q; irqen_d = irqen_q;
    if (wr_en_i && wr_sel_i == SEL_ADDR) addr_d = wr_data_i;
    if (wr_en_i && wr_sel_i == SEL_DATA) data_d = wr_data_i;
    if (rx_load_i) data_d = rx_byte_i;
    if (wr_ctrl) begin
      ack_d = wr_data_i[CB_ACK]; ifen_d = wr_data_i[CB_IFEN]; irqen_d = wr_data_i[CB_IRQEN];
    end
    if (clr_req) flag_d = 1'b0;
    if (evt_valid_i) begin flag_d = 1'b1; code_d = evt_code_i; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; data_q <= '0; code_q <= EV_NONE; flag_q <= 1'b0;
      ack_q <= 1'b0; ifen_q <= 1'b0; irqen_q <= 1'b0;
    end else begin
      addr_q <= addr_d; data_q <= data_d; code_q <= code_d; flag_q <= flag_d;
      ack_q <= ack_d; ifen_q <= ifen_d; irqen_q <= irqen_d;
    end
  end

  assign own_addr_o = addr_q[BYTE_W-1:1];
  assign gc_en_o    = addr_q[0];
  assign ack_en_o   = ack_q;
  assign if_en_o    = ifen_q;
  assign irq_en_o   = irqen_q;
  assign flag_o     = flag_q;
  assign status_o   = flag_q ? code_q : EV_NONE;
  assign data_o     = data_q;

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q);
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_i |=> flag_q);
  a_r5_rx_store: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load_i |=> (data_q == $past(rx_byte_i)));
endmodule

// File: rtl/i2c_tgt_status.sv
module i2c_tgt_status
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  input  logic       wr_en_i,
  input  logic [1:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] data_o,
  output logic [7:0] status_o,
  output logic       flag_o,
  output logic       irq_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic gc_en, ack_en, if_en, irq_en, flag;
  logic [ADDR_W-1:0] own_addr;
  logic evt_valid, rx_load;
  logic [7:0] evt_code;
  logic [BYTE_W-1:0] rx_byte, data_reg;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det));

  i2c_tgt_engine u_engine (
    .clk(clk), .rst_n(rst_n), .if_en_i(if_en), .ack_en_i(ack_en), .gc_en_i(gc_en),
    .own_addr_i(own_addr), .flag_i(flag), .data_reg_i(data_reg), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_det_i(start_det),
    .stop_det_i(stop_det), .sda_oe_o(sda_oe_o), .scl_oe_o(scl_oe_o),
    .evt_valid_o(evt_valid), .evt_code_o(evt_code), .rx_load_o(rx_load),
    .rx_byte_o(rx_byte));

  i2c_tgt_hostregs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .evt_valid_i(evt_valid), .evt_code_i(evt_code),
    .rx_load_i(rx_load), .rx_byte_i(rx_byte), .own_addr_o(own_addr),
    .gc_en_o(gc_en), .ack_en_o(ack_en), .if_en_o(if_en), .irq_en_o(irq_en),
    .flag_o(flag), .status_o(status_o), .data_o(data_reg));

  assign data_o = data_reg;
  assign flag_o = flag;
  assign irq_o  = flag && irq_en;
endmodule

// File: tb/i2c_tgt_status_test.sv
`timescale 1ns/1ps
module i2c_tgt_status_test;
  localparam int H = 8;
  localparam logic [6:0] OWN = 7'h2D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic scl_oe, sda_oe, flag, irq;
  logic [7:0] data_o, status;
  logic scl_line, sda_line;
  logic [7:0] ctrl_base;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2c_tgt_status uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .data_o(data_o), .status_o(status), .flag_o(flag), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hw(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic clr();
    hw(2'd2, ctrl_base | 8'h01);
  endtask

  task automatic scl_high();
    scl_m = 1'b1; tick(1);
    while (scl_oe) tick(1);
    tick(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(H); scl_high(); scl_m = 1'b0; tick(H);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(H); scl_high(); b = sda_line; scl_m = 1'b0; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
  endtask

  task automatic ack_clock(output logic acked);
    logic b;
    recv_bit(b); acked = !b;
  endtask

  task automatic bstart();
    sda_m = 1'b1; tick(H); scl_high(); sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(H); scl_high(); sda_m = 1'b1; tick(2*H);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic a, b;
    logic [7:0] v;
    ctrl_base = 8'h06;
    tick(3);
    // R1 reset state
    chk("R1 flag", flag, 0);
    chk("R1/R12 status", status, 8'hF8);
    chk("R1 irq", irq, 0);
    chk("R1 pins", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1; tick(2);
    hw(2'd0, {OWN, 1'b1});
    hw(2'd2, ctrl_base);

    // R2/R3/R4 address sweep, writes, general call enabled
    for (int ad = 0; ad < 128; ad++) begin
      logic hit; logic [7:0] ec;
      hit = (ad == OWN) || (ad == 0);
      ec  = (ad == 0) ? 8'h70 : 8'h60;
      bstart();
      send_byte({ad[6:0], 1'b0});
      chk(hit ? "R2/R4 addr flag" : "R3 no flag", flag, hit);
      chk(hit ? "R2/R4 addr code" : "R3 status", status, hit ? ec : 8'hF8);
      if (hit) begin
        chk("R9 stretch", scl_oe, 1);
        clr();
        chk("R9 release", scl_oe, 0);
      end
      ack_clock(a);
      chk(hit ? "R2 ack" : "R3 nack", a, hit);
      bstop();
      chk(hit ? "R6 stop code" : "R6 no stop code", status, hit ? 8'hA0 : 8'hF8);
      if (hit) clr();
    end

    // R5/R8/R9 write transfer with several patterns, ended by repeated START
    bstart(); send_byte({OWN, 1'b0});
    chk("R2 write code", status, 8'h60);
    hw(2'd2, ctrl_base);
    chk("R8 flag kept on 0 write", flag, 1);
    chk("R8 status kept", status, 8'h60);
    clr(); ack_clock(a);
    for (int k = 0; k < 4; k++) begin
      v = 8'h3C ^ (8'h5A * k[7:0]);
      send_byte(v);
      chk("R5 rx code", status, 8'h80);
      chk("R5 rx data", data_o, v);
      chk("R9 stretch data", scl_oe, 1);
      clr();
      chk("R9 release data", scl_oe, 0);
      ack_clock(a);
      chk("R5 rx ack", a, 1);
    end
    sda_m = 1'b1; tick(H); scl_high(); sda_m = 1'b0; tick(H);
    chk("R6 repeated start code", status, 8'hA0);
    scl_m = 1'b0; tick(H);
    clr(); bstop();
    chk("R6 stop after rstart unaddressed", flag, 0);

    // R5 NACK path: second byte ignored, no A0
    bstart(); send_byte({OWN, 1'b0});
    ctrl_base = 8'h04; clr(); ack_clock(a);
    send_byte(8'h96);
    chk("R5 nack code", status, 8'h88);
    chk("R5 nack data", data_o, 8'h96);
    clr(); ack_clock(a);
    chk("R5 nack bit", a, 0);
    send_byte(8'h11);
    chk("R5 ignored after nack", flag, 0);
    chk("R5 data unchanged", data_o, 8'h96);
    ack_clock(a);
    bstop();
    chk("R6 no A0 after nack", flag, 0);
    ctrl_base = 8'h06; hw(2'd2, ctrl_base);

    // R4 general call data ACK then NACK
    bstart(); send_byte(8'h00);
    chk("R4 gc code", status, 8'h70);
    clr(); ack_clock(a);
    send_byte(8'hE1);
    chk("R4 gc data ack", status, 8'h90);
    ctrl_base = 8'h04; clr(); ack_clock(a);
    send_byte(8'h1E);
    chk("R4 gc data nack", status, 8'h98);
    clr(); ack_clock(a);
    chk("R4 gc nack bit", a, 0);
    bstop();
    ctrl_base = 8'h06; hw(2'd2, ctrl_base);

    // R4 general call disabled
    hw(2'd0, {OWN, 1'b0});
    bstart(); send_byte(8'h00);
    chk("R4 gc disabled", flag, 0);
    ack_clock(a);
    chk("R4 gc disabled nack", a, 0);
    bstop();

    // R7/R11 read: B8, then C8
    ctrl_base = 8'h0E; hw(2'd2, ctrl_base);
    bstart(); send_byte({OWN, 1'b1});
    chk("R2 read code", status, 8'hA8);
    chk("R11 irq on", irq, 1);
    hw(2'd1, 8'hC3); clr(); ack_clock(a);
    recv_byte(v);
    chk("R7 tx byte1", v, 8'hC3);
    send_bit(1'b0);
    chk("R7 tx ack code", status, 8'hB8);
    ctrl_base = 8'h04; hw(2'd1, 8'h5E); clr();
    recv_byte(v);
    chk("R7 tx byte2", v, 8'h5E);
    send_bit(1'b0);
    chk("R7 tx last code", status, 8'hC8);
    chk("R11 irq off when disabled", irq, 0);
    clr(); bstop();
    chk("R7 no A0 after last", flag, 0);

    // R7 read with NACK
    ctrl_base = 8'h06; hw(2'd2, ctrl_base);
    bstart(); send_byte({OWN, 1'b1});
    hw(2'd1, 8'h81); clr(); ack_clock(a);
    recv_byte(v);
    chk("R7 tx byte nack", v, 8'h81);
    send_bit(1'b1);
    chk("R7 tx nack code", status, 8'hC0);
    clr(); bstop();
    chk("R7 quiet after nack", flag, 0);

    // R10 interface disabled
    ctrl_base = 8'h02; hw(2'd2, ctrl_base);
    bstart(); send_byte({OWN, 1'b0});
    chk("R10 no event", flag, 0);
    ack_clock(a);
    chk("R10 no ack", a, 0);
    bstop();
    chk("R10/R12 status idle", status, 8'hF8);

    b = 1'b0;
    done = 1;
    summary();
  end
endmodule